// File: doc/BRIEF.md
# Byte-Wide SPI Peripheral with Master and Slave Modes

This block is a serial peripheral interface port that sits on a simple byte-wide register bus. Software selects master or slave operation, the master clock rate and the interrupt enable through a control register. It moves one byte per transfer, most significant bit first, in SPI mode 0: data is sampled on the rising SCK edge and changed on the falling edge.

As a master, a write to the data register loads the single transmit buffer and starts an internal SCK generator. The generator runs for exactly eight clock periods and stops by itself. The slave-select line is never driven by the transfer logic. Software owns a separate select output through a control bit. As a slave, the block runs the external SCK, SS and MOSI through synchronizer flops clocked by the system clock and detects the SCK edges there. It shifts only while SS is low, and drives MISO only while SS is low.

A completed byte is copied into a receive buffer that keeps the last byte. A completion flag and an optional interrupt tell software that the byte is ready. A data write that arrives while a byte is moving is dropped and sets a collision bit.

Top module: `spi_port`

## Requirements
- R1: After reset the control register (address 0) reads 8'h08, the status register (address 1) reads 8'h00, irq is 0, sck_out is 0, miso_oe is 0 and ssel_n_out is 1.
- R2: The control register is at address 0, with en at bit 0, master at bit 1, irq_en at bit 2, the select level at bit 3 and the divider code at bits 5:4. With en=1 and master=1, a write to the data register (address 2) shifts that byte out on mosi_out, MSB first. It captures eight miso_in bits, sampled on the rising SCK edges, and a read of address 2 then returns the captured byte.
- R3: In master mode SCK idles low. Its high and low phases each last D/2 system clocks, where the divider code 0, 1, 2 or 3 gives D = 4, 16, 64 or 128. Each transfer has exactly eight rising edges, and SCK is low again when the transfer ends.
- R4: When a byte completes, status bit 7 (done) becomes 1. irq equals done AND irq_en, so with irq_en=0 the done bit still sets but irq stays 0.
- R5: Done (bit 7) and collision (bit 6) clear only after a status read that sees either bit set, followed by a read or write of the data register. A data access without that earlier status read leaves them set.
- R6: A data write while a byte is moving is ignored: the byte already being shifted is unchanged, and status bit 6 (collision) is set.
- R7: ssel_n_out always equals control bit 3 and is never changed by a transfer.
- R8: In slave mode (en=1, master=0) with ss_n_in high, miso_oe is 0, SCK edges on sck_in shift nothing and do not set done, and a data write still loads the transmit byte.
- R9: In slave mode with ss_n_in low, miso_oe is 1. The block captures mosi_in on the rising edges of sck_in, MSB first, and presents the loaded byte on miso_out, MSB first. This requires SCK high and low phases longer than two system clocks.
- R10: The receive buffer keeps the last completed byte through repeated reads. A byte that completes before the previous one was read overwrites it.
- R11: In slave mode a rising edge on ss_n_in clears the bit count, so a partial byte is discarded and the next byte starts at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Master serial clock |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| ssel_n_out | output | 1 | Software-controlled slave select |
| sck_in | input | 1 | Slave serial clock |
| ss_n_in | input | 1 | Slave select, active low |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Output enable for miso_out |

## Verification
The bench builds the block with the default counter width of 7 bits, which holds the largest half period of 64 clocks. Because of that, all four divider codes are exercised, including the slowest, and each one's measured SCK phase length is compared with its divisor. Slave transfers run with SCK phases of four system clocks, just above the synchronizer's limit. This brings the edge-detection latency against the MISO update into reach, along with the select-rise realignment after a partial byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int HALF_W = 7;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic [1:0] spare;
    logic [1:0] div;
    logic       ssel_n;
    logic       irq_en;
    logic       master;
    logic       en;
  } ctrl_t;

  // half SCK period in system clocks for divider code
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] code);
    case (code)
      2'd0:    half_period = 7'd2;
      2'd1:    half_period = 7'd8;
      2'd2:    half_period = 7'd32;
      default: half_period = 7'd64;
    endcase
  endfunction
endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] half,
  output logic          sck,
  output logic          run,
  output logic          rise,
  output logic          fall
);
  logic [CW-1:0] cnt;
  logic [3:0]    tgl;
  logic          tick;

  assign tick = run && (cnt == half - 1'b1);
  assign rise = tick & ~sck;
  assign fall = tick & sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; sck <= 1'b0; cnt <= '0; tgl <= '0;
    end else if (start) begin
      run <= 1'b1; sck <= 1'b0; cnt <= '0; tgl <= '0;
    end else if (run) begin
      if (tick) begin
        cnt <= '0;
        sck <= ~sck;
        tgl <= tgl + 4'd1;
        if (tgl == 4'd15) run <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: generator always stops with SCK low
  p_stop_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !sck);
endmodule

// File: rtl/spi_port_sync.sv
module spi_port_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic ss_n_in,
  input  logic mosi_in,
  output logic ss_n_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic ss_rise
);
  logic [2:0] sck_p, ss_p;
  logic [1:0] mo_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0; ss_p <= '1; mo_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck_in};
      ss_p  <= {ss_p[1:0], ss_n_in};
      mo_p  <= {mo_p[0], mosi_in};
    end
  end

  assign sck_rise = sck_p[1] & ~sck_p[2];
  assign sck_fall = ~sck_p[1] & sck_p[2];
  assign ss_rise  = ss_p[1] & ~ss_p[2];
  assign ss_n_s   = ss_p[1];
  assign mosi_s   = mo_p[1];
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int W = 8,
  localparam int BW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         cap,
  input  logic         adv,
  input  logic         din,
  input  logic         clr_cnt,
  output logic         dout,
  output logic [W-1:0] rx_byte,
  output logic         byte_done,
  output logic         mid
);
  logic [W-1:0]  tx_sr;
  logic [W-2:0]  rx_sr;
  logic [BW-1:0] bitcnt;

  assign dout      = tx_sr[W-1];
  assign rx_byte   = {rx_sr, din};
  assign mid       = (bitcnt != '0);
  assign byte_done = cap && (bitcnt == BW'(W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0; rx_sr <= '0; bitcnt <= '0;
    end else begin
      if (load)             tx_sr <= load_data;
      else if (adv && mid)  tx_sr <= {tx_sr[W-2:0], 1'b0};
      if (clr_cnt)          bitcnt <= '0;
      else if (cap)         bitcnt <= bitcnt + 1'b1;
      if (cap)              rx_sr <= rx_byte[W-2:0];
    end
  end

  // R11: a clear request realigns the next byte to bit 7
  p_cnt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (bitcnt == '0));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int CW = HALF_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck_out,
  output logic       mosi_out,
  input  logic       miso_in,
  output logic       ssel_n_out,
  input  logic       sck_in,
  input  logic       ss_n_in,
  input  logic       mosi_in,
  output logic       miso_out,
  output logic       miso_oe
);
  ctrl_t      ctrl;
  logic       flag, wcol, armed;
  logic [7:0] rx_buf, rx_byte;

  // named internal events
  logic data_wr, data_rd, stat_rd, clear_ev;
  logic mst_mode, slv_mode, busy, wr_accept, wr_collide, start;
  logic g_run, g_rise, g_fall, g_sck;
  logic ss_n_s, mosi_s, s_rise, s_fall, ss_rise;
  logic cap, adv, din, clr_cnt, sh_dout, byte_done, sh_mid;

  assign data_wr    = bus_wr && (bus_addr == A_DATA);
  assign data_rd    = bus_rd && (bus_addr == A_DATA);
  assign stat_rd    = bus_rd && (bus_addr == A_STAT);
  assign clear_ev   = armed && (data_wr || data_rd);
  assign mst_mode   = ctrl.en & ctrl.master;
  assign slv_mode   = ctrl.en & ~ctrl.master;
  assign busy       = mst_mode ? g_run : (slv_mode & sh_mid);
  assign wr_accept  = data_wr & ~busy;
  assign wr_collide = data_wr & busy;
  assign start      = wr_accept & mst_mode;

  spi_port_clkgen #(.CW(CW)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .half(CW'(half_period(ctrl.div))),
    .sck(g_sck), .run(g_run), .rise(g_rise), .fall(g_fall));

  spi_port_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ss_n_in(ss_n_in),
    .mosi_in(mosi_in), .ss_n_s(ss_n_s), .mosi_s(mosi_s),
    .sck_rise(s_rise), .sck_fall(s_fall), .ss_rise(ss_rise));

  assign cap     = mst_mode ? g_rise : (slv_mode & ~ss_n_s & s_rise);
  assign adv     = mst_mode ? g_fall : (slv_mode & ~ss_n_s & s_fall);
  assign din     = mst_mode ? miso_in : mosi_s;
  assign clr_cnt = ~ctrl.en | (slv_mode & ss_rise);

  spi_port_shifter #(.W(8)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(wr_accept), .load_data(bus_wdata),
    .cap(cap), .adv(adv), .din(din), .clr_cnt(clr_cnt),
    .dout(sh_dout), .rx_byte(rx_byte), .byte_done(byte_done), .mid(sh_mid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= ctrl_t'(8'h08);
      flag   <= 1'b0;
      wcol   <= 1'b0;
      armed  <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl <= ctrl_t'(bus_wdata);
      if (byte_done)     flag <= 1'b1;
      else if (clear_ev) flag <= 1'b0;
      if (wr_collide)    wcol <= 1'b1;
      else if (clear_ev) wcol <= 1'b0;
      if (stat_rd && (flag || wcol)) armed <= 1'b1;
      else if (clear_ev)             armed <= 1'b0;
      if (byte_done) rx_buf <= rx_byte;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = {flag, wcol, 6'b0};
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq        = flag & ctrl.irq_en;
  assign sck_out    = g_sck;
  assign mosi_out   = mst_mode & sh_dout;
  assign miso_out   = sh_dout;
  assign miso_oe    = slv_mode & ~ss_n_s;
  assign ssel_n_out = ctrl.ssel_n;

  // R4: a completed byte raises the done flag
  p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> flag);
  // R6: a data write during a transfer records a collision
  p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |=> wcol);
  // R8: a deselected slave never completes a byte
  p_slave_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_mode && ss_n_s) |-> !byte_done);
  // R10: receive buffer only changes on byte completion
  p_rxbuf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_buf));
endmodule

// File: tb/spi_port_tb_top.sv
`timescale 1ns/1ps
module spi_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       irq, sck_out, mosi_out, miso_in, ssel_n_out;
  logic       sck_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;
  logic       miso_out, miso_oe;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_port dut_i (.*);

  // bench-side slave for master tests
  logic [7:0] bs_tx = '0, bs_rx = '0;
  int rise_cnt = 0, t_r1 = 0, t_r2 = 0;
  assign miso_in = bs_tx[7];
  always @(posedge sck_out) begin
    bs_rx = {bs_rx[6:0], mosi_out};
    rise_cnt++;
    if (rise_cnt == 1) t_r1 = cyc;
    if (rise_cnt == 2) t_r2 = cyc;
  end
  always @(negedge sck_out) bs_tx = {bs_tx[6:0], 1'b0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // divisor 4,16,64,128 for codes 0..3, half of it per phase
  function automatic int exp_half(input int code);
    int d;
    d = (code == 3) ? 128 : (4 << (2 * code));
    return d / 2;
  endfunction

  // bench acts as SPI master toward the slave: 4-clock phases
  logic [7:0] got_miso;
  task automatic slv_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mosi_in = b[7 - i];
      idle(4);
      sck_in = 1'b1; got_miso = {got_miso[6:0], miso_out};
      idle(4);
      sck_in = 1'b0;
    end
    idle(6);
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    rd(2'd1, d); rd(2'd2, d);
  endtask

  // {div code, byte sent by DUT, byte replied by bench slave}
  localparam logic [17:0] VEC [4] = '{
    {2'd0, 8'hA5, 8'h3C},
    {2'd1, 8'h81, 8'h7E},
    {2'd2, 8'h00, 8'hFF},
    {2'd3, 8'h5A, 8'hC3}
  };

  initial begin
    logic [7:0] d;
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 8'h08);
    rd(2'd1, d); chk("R1 status", d, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 sck", sck_out, 1'b0);
    chk("R1 miso_oe", miso_oe, 1'b0);
    chk("R1 ssel", ssel_n_out, 1'b1);

    // R2/R3/R4/R5 master vectors
    foreach (VEC[k]) begin
      int code;
      code = int'(VEC[k][17:16]);
      wr(2'd0, {2'b00, VEC[k][17:16], 4'b0111});
      bs_tx = VEC[k][7:0]; rise_cnt = 0;
      wr(2'd2, VEC[k][15:8]);
      repeat (16 * exp_half(code) + 8) @(posedge clk);
      @(negedge clk);
      chk("R2 mosi byte", bs_rx, VEC[k][15:8]);
      chk("R3 rise count", rise_cnt, 8);
      chk("R3 half period", (t_r2 - t_r1) / 2, exp_half(code));
      chk("R3 sck idle", sck_out, 1'b0);
      chk("R4 irq", irq, 1'b1);
      chk("R7 ssel low", ssel_n_out, 1'b0);
      rd(2'd2, d); chk("R2 rx byte", d, VEC[k][7:0]);
      rd(2'd1, d); chk("R5 no clear w/o status", d, 8'h80);
      rd(2'd2, d);
      rd(2'd1, d); chk("R5 cleared", d, 8'h00);
    end

    // R6 collision
    wr(2'd0, 8'h07); bs_tx = 8'h00;
    wr(2'd2, 8'h3C); idle(6);
    wr(2'd2, 8'hEE); idle(40);
    chk("R6 byte unchanged", bs_rx, 8'h3C);
    rd(2'd1, d); chk("R6 collision", d, 8'hC0);
    rd(2'd2, d); rd(2'd1, d); chk("R5 both cleared", d, 8'h00);

    // R4 irq disabled, R7 select high
    wr(2'd0, 8'h0B);
    chk("R7 ssel high", ssel_n_out, 1'b1);
    wr(2'd2, 8'h11); idle(40);
    chk("R4 irq masked", irq, 1'b0);
    rd(2'd1, d); chk("R4 flag set", d, 8'h80);
    clear_flags();

    // slave mode
    wr(2'd0, 8'h05); idle(4);
    chk("R8 miso hiZ", miso_oe, 1'b0);
    slv_bits(8'hFF, 8);
    rd(2'd1, d); chk("R8 no shift", d, 8'h00);
    wr(2'd2, 8'h96);
    ss_n_in = 1'b0; idle(4);
    chk("R9 miso driven", miso_oe, 1'b1);
    slv_bits(8'h4B, 8);
    chk("R9 miso byte", got_miso, 8'h96);
    chk("R9 irq", irq, 1'b1);
    // R10 overrun without read
    slv_bits(8'h21, 8);
    rd(2'd1, d); rd(2'd2, d); chk("R10 overwrite", d, 8'h21);
    rd(2'd2, d); chk("R10 kept", d, 8'h21);

    // R11 realign on select rise
    clear_flags();
    slv_bits(8'hFF, 3);
    ss_n_in = 1'b1; idle(6);
    rd(2'd1, d); chk("R11 partial discarded", d, 8'h00);
    ss_n_in = 1'b0; idle(4);
    slv_bits(8'hC7, 8);
    rd(2'd1, d); chk("R11 flag", d, 8'h80);
    rd(2'd2, d); chk("R11 aligned byte", d, 8'hC7);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule